// File: doc/BRIEF.md
# Indexed Register and Memory Window

This block is a memory-mapped slave that gives a host two ways to reach storage through a small register space. A 32-bit index register sits at byte offset 0x0. A four-byte data window sits at offsets 0x4 to 0x7. A host can also address any other register of the space directly. When the host accesses the window, the block looks at the top bit of the index. If that bit is set, the access goes to a video-memory port at the index address, with a bounds check. If that bit is clear, the access goes back into the register space at the index plus the byte offset within the window.

Every access carries a size of 1, 2 or 4 bytes. Register accesses extract or insert byte lanes of a 32-bit word, little-endian. A narrow write is done as a read-modify-write on the external register-file port, so the bytes that are not addressed keep their values. One register, the command-queue status word, is answered by the block itself and always reports a fixed count of free entries. The bus uses a valid/ready request and a valid/ready response, and it allows one access in flight.

Top module: `idxwin_top`

## Requirements
- R1: The index register is at byte offsets 0x0 to 0x3. It is read and written with the same byte-lane rules as other registers (R5, R6). Reset clears it to zero.
- R2: If a window access is made while index bit 31 is 1, it goes to the memory port at byte address index[30:0]. The window byte offset is not added. Data is little-endian: request data byte k (bits 8k+7..8k) is the memory byte at address+k, and mem_be bit k is set for k below the access size.
- R3: A memory access happens only when index[30:0] + size <= MEM_BYTES. Otherwise no memory request is issued, a write is dropped and a read returns 0.
- R4: If a window access is made while index bit 31 is 0, it goes to the register at byte address index + (addr - 4).
- R5: A read of size n at register byte address t returns bits starting at t[1:0]*8, n*8 bits wide, in the low bits of rsp_rdata. A byte beyond bit 31 of the word reads as 0. An aligned 4-byte read returns the whole word.
- R6: A write of size n at register byte address t replaces only the addressed bytes of the 32-bit word and keeps all other bytes. A byte beyond the word is dropped. req_size encodes 0 as 1 byte, 1 as 2 bytes, and 2 or 3 as 4 bytes.
- R7: The word at FIFO_ADDR reads as FREE_ENTRIES (64 by default), with the normal byte-lane rules. Writes to it are ignored.
- R8: An indirect target below byte 8 (the index or the window itself), or at or above REG_BYTES, reads as 0. A write to such a target changes nothing, and the register-file port is not written.
- R9: At most one access is in flight. req_ready is low from the accepting edge until the response has been taken. rsp_valid and rsp_rdata are held until rsp_ready. A write responds with rsp_rdata = 0.
- R10: After reset, req_ready is 1, rsp_valid is 0 and the index reads as 0.
- R11: A direct access at byte address 8 or above reaches the register file at that address with the rules of R5 and R6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Block can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | RAW | Byte address in register space |
| req_size | input | 2 | Access size code (R6) |
| req_wdata | input | 32 | Write data, low bytes used |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Host takes the response |
| rsp_rdata | output | 32 | Read data, low bytes used |
| mem_req | output | 1 | Memory access strobe, one cycle |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | MAW | Memory byte address |
| mem_be | output | 4 | Memory byte enables |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, one cycle after mem_req |
| rf_addr | output | RAW-2 | Register-file word address |
| rf_rdata | input | 32 | Register-file word, combinational from rf_addr |
| rf_we | output | 1 | Register-file word write |
| rf_wdata | output | 32 | Merged word to write |

## Verification
The hardest cases to reach are the indirect ones, because the result depends on the index written earlier, not on the address of the current request. The stimulus first sets up each index value through the index register, sometimes one byte at a time. It then issues window accesses whose targets land on a byte lane that runs past the word, on the status word, back on the index or window, and just inside and just outside the memory bound. A shadow model of the index, the registers and the memory predicts each response. Ignored writes are checked by reading back the state they could have changed, while a stalling response-ready pattern exercises the single-access handshake.

// File: rtl/idxwin_pkg.sv
package idxwin_pkg;

   localparam int unsigned WORD_W    = 32;
   localparam int unsigned WIN_LO    = 4;
   localparam int unsigned SPACE_LO  = 8;

   typedef enum logic [2:0] {
      K_INDEX,
      K_MEM,
      K_MEM_OUT,
      K_RF,
      K_FIFO,
      K_NULL
   } kind_e;

   typedef enum logic [1:0] {
      S_IDLE,
      S_EXEC,
      S_MWAIT,
      S_RESP
   } state_e;

   function automatic logic [2:0] size_bytes(input logic [1:0] code);
      case (code)
         2'd0:    size_bytes = 3'd1;
         2'd1:    size_bytes = 3'd2;
         default: size_bytes = 3'd4;
      endcase
   endfunction

endpackage

// File: rtl/idxwin_lane.sv
module idxwin_lane #(
   parameter int unsigned DW = 32,
   localparam int unsigned LANES = DW / 8,
   localparam int unsigned OW = $clog2(LANES),
   localparam int unsigned NW = OW + 1
) (
   input  logic [DW-1:0] word_i,
   input  logic [OW-1:0] off_i,
   input  logic [NW-1:0] nb_i,
   input  logic [DW-1:0] wdata_i,
   output logic [DW-1:0] rd_o,
   output logic [DW-1:0] merged_o,
   output logic [DW-1:0] fld_mask_o
);
   logic [DW-1:0]   pos_mask;
   logic [OW+2:0]   shamt;

   for (genvar k = 0; k < LANES; k++) begin : g_lane
      assign fld_mask_o[k*8 +: 8] = (NW'(k) < nb_i) ? 8'hFF : 8'h00;
   end

   assign shamt    = {off_i, 3'b000};
   assign pos_mask = fld_mask_o << shamt;
   assign rd_o     = (word_i >> shamt) & fld_mask_o;
   assign merged_o = (word_i & ~pos_mask) | ((wdata_i << shamt) & pos_mask);
endmodule

// File: rtl/idxwin_route.sv
module idxwin_route
   import idxwin_pkg::*;
#(
   parameter int unsigned REG_BYTES = 16384,
   parameter longint unsigned MEM_BYTES = 64'd16777216,
   parameter logic [31:0] FIFO_ADDR = 32'h0000_0740,
   parameter bit          FIFO_EN   = 1'b1,
   localparam int unsigned RAW = $clog2(REG_BYTES)
) (
   input  logic [RAW-1:0] addr_i,
   input  logic [31:0]    index_i,
   input  logic [2:0]     nb_i,
   output kind_e          kind_o,
   output logic [31:0]    tgt_o
);
   logic        is_index, is_win, is_fifo, mem_fit, out_space;
   logic [32:0] mem_end;

   assign is_index = (32'(addr_i) < WIN_LO);
   assign is_win   = !is_index && (32'(addr_i) < SPACE_LO);
   assign tgt_o    = is_win ? (index_i + {30'd0, addr_i[1:0]}) : 32'(addr_i);

   assign mem_end  = {2'b00, index_i[30:0]} + 33'(nb_i);
   assign mem_fit  = (mem_end <= 33'(MEM_BYTES));
   assign out_space = (tgt_o < SPACE_LO) || (tgt_o >= REG_BYTES);

   if (FIFO_EN) begin : g_fifo
      assign is_fifo = (tgt_o[31:2] == FIFO_ADDR[31:2]);
   end else begin : g_nofifo
      assign is_fifo = 1'b0;
   end

   always_comb begin
      if (is_index)                  kind_o = K_INDEX;
      else if (is_win && index_i[31]) kind_o = mem_fit ? K_MEM : K_MEM_OUT;
      else if (out_space)            kind_o = K_NULL;
      else if (is_fifo)              kind_o = K_FIFO;
      else                           kind_o = K_RF;
   end
endmodule

// File: rtl/idxwin_top.sv
module idxwin_top
   import idxwin_pkg::*;
#(
   parameter int unsigned     REG_BYTES    = 16384,
   parameter longint unsigned MEM_BYTES    = 64'd16777216,
   parameter logic [31:0]     FIFO_ADDR    = 32'h0000_0740,
   parameter bit              FIFO_EN      = 1'b1,
   parameter logic [31:0]     FREE_ENTRIES = 32'd64,
   localparam int unsigned RAW = $clog2(REG_BYTES),
   localparam int unsigned MAW = $clog2(MEM_BYTES)
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           req_valid,
   output logic           req_ready,
   input  logic           req_write,
   input  logic [RAW-1:0] req_addr,
   input  logic [1:0]     req_size,
   input  logic [31:0]    req_wdata,
   output logic           rsp_valid,
   input  logic           rsp_ready,
   output logic [31:0]    rsp_rdata,
   output logic           mem_req,
   output logic           mem_we,
   output logic [MAW-1:0] mem_addr,
   output logic [3:0]     mem_be,
   output logic [31:0]    mem_wdata,
   input  logic [31:0]    mem_rdata,
   output logic [RAW-3:0] rf_addr,
   input  logic [31:0]    rf_rdata,
   output logic           rf_we,
   output logic [31:0]    rf_wdata
);
   if (REG_BYTES < 16 || (1 << RAW) != REG_BYTES) begin : g_chk_reg
      $error("REG_BYTES must be a power of two of at least 16");
   end
   if (MEM_BYTES < 4 || MEM_BYTES > 64'h8000_0000 || (64'd1 << MAW) != MEM_BYTES) begin : g_chk_mem
      $error("MEM_BYTES must be a power of two between 4 and 2^31");
   end
   if (FIFO_EN && (FIFO_ADDR[1:0] != 2'b00 || FIFO_ADDR < SPACE_LO || FIFO_ADDR >= REG_BYTES)) begin : g_chk_fifo
      $error("FIFO_ADDR must be word aligned inside the register space above the window");
   end

   state_e         st;
   logic [31:0]    index_q;
   logic [31:0]    rsp_q;
   logic           cap_write;
   logic [RAW-1:0] cap_addr;
   logic [2:0]     cap_nb;
   logic [31:0]    cap_wdata;

   kind_e          kind;
   logic [31:0]    tgt;
   logic [31:0]    lane_word, lane_rd, lane_merged, lane_mask;

   idxwin_route #(
      .REG_BYTES (REG_BYTES),
      .MEM_BYTES (MEM_BYTES),
      .FIFO_ADDR (FIFO_ADDR),
      .FIFO_EN   (FIFO_EN)
   ) u_route (
      .addr_i  (cap_addr),
      .index_i (index_q),
      .nb_i    (cap_nb),
      .kind_o  (kind),
      .tgt_o   (tgt)
   );

   always_comb begin
      case (kind)
         K_INDEX: lane_word = index_q;
         K_FIFO:  lane_word = FREE_ENTRIES;
         default: lane_word = rf_rdata;
      endcase
   end

   idxwin_lane #(.DW(WORD_W)) u_lane (
      .word_i     (lane_word),
      .off_i      (tgt[1:0]),
      .nb_i       (cap_nb),
      .wdata_i    (cap_wdata),
      .rd_o       (lane_rd),
      .merged_o   (lane_merged),
      .fld_mask_o (lane_mask)
   );

   for (genvar k = 0; k < 4; k++) begin : g_be
      assign mem_be[k] = lane_mask[k*8];
   end

   assign req_ready = (st == S_IDLE);
   assign rsp_valid = (st == S_RESP);
   assign rsp_rdata = rsp_q;

   assign mem_req   = (st == S_EXEC) && (kind == K_MEM);
   assign mem_we    = cap_write;
   assign mem_addr  = index_q[MAW-1:0];
   assign mem_wdata = cap_wdata & lane_mask;

   assign rf_addr   = tgt[RAW-1:2];
   assign rf_we     = (st == S_EXEC) && (kind == K_RF) && cap_write;
   assign rf_wdata  = lane_merged;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st        <= S_IDLE;
         index_q   <= '0;
         rsp_q     <= '0;
         cap_write <= 1'b0;
         cap_addr  <= '0;
         cap_nb    <= 3'd4;
         cap_wdata <= '0;
      end else begin
         case (st)
            S_IDLE: begin
               if (req_valid) begin
                  cap_write <= req_write;
                  cap_addr  <= req_addr;
                  cap_nb    <= size_bytes(req_size);
                  cap_wdata <= req_wdata;
                  st        <= S_EXEC;
               end
            end
            S_EXEC: begin
               case (kind)
                  K_INDEX: begin
                     if (cap_write) index_q <= lane_merged;
                     rsp_q <= cap_write ? 32'd0 : lane_rd;
                     st    <= S_RESP;
                  end
                  K_MEM: begin
                     rsp_q <= 32'd0;
                     st    <= cap_write ? S_RESP : S_MWAIT;
                  end
                  K_RF, K_FIFO: begin
                     rsp_q <= cap_write ? 32'd0 : lane_rd;
                     st    <= S_RESP;
                  end
                  default: begin
                     rsp_q <= 32'd0;
                     st    <= S_RESP;
                  end
               endcase
            end
            S_MWAIT: begin
               rsp_q <= mem_rdata & lane_mask;
               st    <= S_RESP;
            end
            default: begin
               if (rsp_ready) st <= S_IDLE;
            end
         endcase
      end
   end

   // response is held while the host stalls
   assert_rsp_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_rdata));

   // acceptance closes the request side until the response is taken
   assert_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && req_ready |=> !req_ready);

   assert_write_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && cap_write |-> rsp_rdata == 32'd0);

   assert_mem_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> ({1'b0, index_q[30:0]} + 32'(cap_nb)) <= 32'(MEM_BYTES));

   assert_mem_sel_R2: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> index_q[31] && !rf_we);

   assert_no_loop_R8: assert property (@(posedge clk) disable iff (!rst_n)
      rf_we |-> rf_addr >= (RAW-2)'(2));
endmodule

// File: tb/idxwin_top_bench.sv
module idxwin_top_bench;
   localparam int CLK_P = 10;
   localparam int REGB  = 64;
   localparam int MEMB  = 256;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0, req_write = 1'b0, rsp_ready = 1'b0;
   logic [5:0]  req_addr = '0;
   logic [1:0]  req_size = '0;
   logic [31:0] req_wdata = '0;
   logic        req_ready, rsp_valid;
   logic [31:0] rsp_rdata;
   logic        mem_req, mem_we;
   logic [7:0]  mem_addr;
   logic [3:0]  mem_be;
   logic [31:0] mem_wdata, mem_rdata;
   logic [3:0]  rf_addr;
   logic [31:0] rf_rdata, rf_wdata;
   logic        rf_we;

   int errors = 0, checks = 0, cyc = 0;
   logic done = 1'b0;

   logic [7:0]  env_mem [MEMB];
   logic [31:0] env_rf  [REGB/4];
   logic [7:0]  sh_mem  [MEMB];
   logic [31:0] sh_rf   [REGB/4];
   logic [31:0] sh_idx;
   logic [31:0] exp_q[$];
   string       tag_q[$];

   always #(CLK_P/2) clk = ~clk;

   idxwin_top #(
      .REG_BYTES(REGB), .MEM_BYTES(64'(MEMB)), .FIFO_ADDR(32'h30),
      .FIFO_EN(1'b1), .FREE_ENTRIES(32'd64)
   ) u_idxwin_top (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_write(req_write), .req_addr(req_addr), .req_size(req_size),
      .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
      .rsp_rdata(rsp_rdata), .mem_req(mem_req), .mem_we(mem_we),
      .mem_addr(mem_addr), .mem_be(mem_be), .mem_wdata(mem_wdata),
      .mem_rdata(mem_rdata), .rf_addr(rf_addr), .rf_rdata(rf_rdata),
      .rf_we(rf_we), .rf_wdata(rf_wdata)
   );

   // environment: register file and memory behind the block
   assign rf_rdata = env_rf[rf_addr];
   always @(posedge clk) begin
      if (rf_we) env_rf[rf_addr] <= rf_wdata;
      if (mem_req && mem_we) begin
         for (int k = 0; k < 4; k++)
            if (mem_be[k]) env_mem[8'(mem_addr + 8'(k))] <= mem_wdata[k*8 +: 8];
      end
      if (mem_req && !mem_we)
         mem_rdata <= {env_mem[8'(mem_addr+8'd3)], env_mem[8'(mem_addr+8'd2)],
                       env_mem[8'(mem_addr+8'd1)], env_mem[mem_addr]};
   end

   function automatic logic [31:0] msk(input int n);
      return (n == 1) ? 32'hFF : (n == 2) ? 32'hFFFF : 32'hFFFF_FFFF;
   endfunction
   function automatic logic [31:0] ext(input logic [31:0] w, input int off, input int n);
      logic [31:0] s;
      s = w >> (off * 8);
      return s & msk(n);
   endfunction
   function automatic logic [31:0] ins(input logic [31:0] w, input int off, input int n,
                                       input logic [31:0] d);
      logic [31:0] pm, ds;
      pm = msk(n) << (off * 8);
      ds = d << (off * 8);
      return (w & ~pm) | (ds & pm);
   endfunction

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // shadow model built from the requirements
   task automatic reg_model(input logic wr, input logic [31:0] t, input int n,
                            input logic [31:0] wd, output logic [31:0] e);
      e = 32'd0;
      if (t < 8 || t >= REGB) e = 32'd0;
      else if (t[31:2] == 30'd12) e = wr ? 32'd0 : ext(32'd64, int'(t[1:0]), n);
      else begin
         if (wr) sh_rf[t[5:2]] = ins(sh_rf[t[5:2]], int'(t[1:0]), n, wd);
         else    e = ext(sh_rf[t[5:2]], int'(t[1:0]), n);
      end
   endtask

   task automatic model(input logic wr, input logic [5:0] a, input logic [1:0] sz,
                        input logic [31:0] wd, output logic [31:0] e);
      int n;
      int unsigned ma;
      n = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
      e = 32'd0;
      if (a < 4) begin
         if (wr) sh_idx = ins(sh_idx, int'(a[1:0]), n, wd);
         else    e = ext(sh_idx, int'(a[1:0]), n);
      end else if (a < 8) begin
         if (sh_idx[31]) begin
            ma = int'(sh_idx[30:0]);
            if (ma + n <= MEMB) begin
               for (int k = 0; k < n; k++) begin
                  if (wr) sh_mem[ma+k] = wd[k*8 +: 8];
                  else    e[k*8 +: 8] = sh_mem[ma+k];
               end
            end
         end else reg_model(wr, sh_idx + 32'(a - 6'd4), n, wd, e);
      end else reg_model(wr, 32'(a), n, wd, e);
   endtask

   task automatic acc(input logic wr, input logic [5:0] a, input logic [1:0] sz,
                      input logic [31:0] wd, input string tag);
      logic [31:0] e;
      model(wr, a, sz, wd, e);
      exp_q.push_back(e);
      tag_q.push_back(tag);
      @(negedge clk);
      req_valid <= 1'b1; req_write <= wr; req_addr <= a; req_size <= sz; req_wdata <= wd;
      forever begin
         #(CLK_P/4);
         if (req_ready) break;
         @(negedge clk);
      end
      @(posedge clk);
      #(CLK_P/4);
      req_valid <= 1'b0;
   endtask

   // response backpressure pattern
   initial begin
      forever begin
         @(negedge clk);
         rsp_ready <= (cyc % 5) != 2;
      end
   end

   // monitor: pops expected responses
   initial begin
      forever begin
         @(negedge clk);
         #(CLK_P/4);
         if (rsp_valid && rsp_ready) begin
            if (exp_q.size() == 0) check("R9 unexpected response", rsp_rdata, 32'hx);
            else check(tag_q.pop_front(), rsp_rdata, exp_q.pop_front());
         end
      end
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc == 20000 && !done) begin
         checks++; errors++;
         $display("FAIL R9 watchdog actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < MEMB; i++) begin
         env_mem[i] = 8'(i * 7 + 3);
         sh_mem[i]  = 8'(i * 7 + 3);
      end
      for (int i = 0; i < REGB/4; i++) begin
         env_rf[i] = 32'hC0DE_0000 | 32'(i * 17);
         sh_rf[i]  = 32'hC0DE_0000 | 32'(i * 17);
      end
      sh_idx = 32'd0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #(CLK_P/4);
      check("R10 req_ready after reset", 32'(req_ready), 32'd1);
      check("R10 rsp_valid after reset", 32'(rsp_valid), 32'd0);
      acc(0, 6'h0, 2'd2, 0, "R10 index reads zero");

      acc(1, 6'h0, 2'd2, 32'h20, "R1 write index");
      acc(0, 6'h0, 2'd2, 0, "R1 read index");
      acc(1, 6'h3, 2'd0, 32'h80, "R1 R6 byte write index lane 3");
      acc(0, 6'h2, 2'd1, 0, "R5 half read index");
      acc(0, 6'h0, 2'd2, 0, "R6 index other bytes kept");

      acc(1, 6'h0, 2'd2, 32'h8000_0010, "R2 index to memory");
      acc(1, 6'h4, 2'd2, 32'h4433_2211, "R2 window write word");
      acc(0, 6'h6, 2'd0, 0, "R2 byte offset not added");
      acc(0, 6'h4, 2'd1, 0, "R2 half read");
      acc(0, 6'h0, 2'd3, 0, "R6 size code 3 word");
      check("R2 little-endian byte 0", 32'(env_mem[16]), 32'h11);
      check("R2 little-endian byte 3", 32'(env_mem[19]), 32'h44);

      acc(1, 6'h0, 2'd2, 32'h8000_00FC, "R3 index last word");
      acc(0, 6'h4, 2'd2, 0, "R3 read at bound");
      acc(1, 6'h0, 2'd0, 32'hFD, "R3 index past bound");
      acc(0, 6'h4, 2'd2, 0, "R3 read past bound is zero");
      acc(1, 6'h4, 2'd2, 32'hDEAD_BEEF, "R3 write past bound");
      acc(1, 6'h0, 2'd0, 32'hFF, "R3 index last byte");
      acc(0, 6'h4, 2'd0, 0, "R3 single byte at end");
      acc(1, 6'h0, 2'd0, 32'hFC, "R3 index back");
      acc(0, 6'h4, 2'd2, 0, "R3 dropped write left memory");

      acc(1, 6'h0, 2'd2, 32'h10, "R4 index to register");
      acc(1, 6'h4, 2'd2, 32'hA1B2_C3D4, "R4 window write register");
      acc(0, 6'h10, 2'd2, 0, "R4 R11 direct readback");
      acc(1, 6'h6, 2'd0, 32'h5A, "R4 R6 byte write via window");
      acc(0, 6'h10, 2'd2, 0, "R6 merged word");
      acc(0, 6'h5, 2'd1, 0, "R5 half read at byte 1");
      acc(0, 6'h7, 2'd1, 0, "R5 half read past word end");
      acc(1, 6'h7, 2'd2, 32'h1122_3344, "R6 write past word end");
      acc(0, 6'h10, 2'd2, 0, "R6 only in-word byte written");

      acc(1, 6'h22, 2'd1, 32'hBEEF, "R11 direct half write");
      acc(0, 6'h20, 2'd2, 0, "R11 direct readback");
      acc(0, 6'h21, 2'd0, 0, "R11 direct byte read");

      acc(0, 6'h30, 2'd2, 0, "R7 status direct");
      acc(1, 6'h30, 2'd2, 32'hFFFF, "R7 status write");
      acc(0, 6'h30, 2'd2, 0, "R7 status unchanged");
      acc(0, 6'h31, 2'd0, 0, "R7 status byte 1");
      acc(1, 6'h0, 2'd2, 32'h30, "R7 index to status");
      acc(0, 6'h4, 2'd0, 0, "R7 status via window");

      acc(1, 6'h0, 2'd2, 32'h4, "R8 index to window");
      acc(1, 6'h4, 2'd2, 32'h1234_5678, "R8 looping write");
      acc(0, 6'h0, 2'd2, 0, "R8 index unchanged");
      acc(0, 6'h4, 2'd2, 0, "R8 looping read zero");
      acc(1, 6'h0, 2'd2, 32'h0, "R8 index to index");
      acc(1, 6'h4, 2'd2, 32'h9999_9999, "R8 write onto index");
      acc(0, 6'h0, 2'd2, 0, "R8 index still zero");
      acc(1, 6'h0, 2'd2, 32'h40, "R8 index out of space");
      acc(0, 6'h4, 2'd2, 0, "R8 out of space read zero");

      while (exp_q.size() != 0) @(negedge clk);
      repeat (3) @(negedge clk);
      check("R9 all responses seen", 32'(exp_q.size()), 32'd0);
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule